// File: doc/BRIEF.md
# Floating-point widening converter

This block turns a narrower IEEE-754 binary floating-point value into the next wider format. A mode input chooses the conversion: a 16-bit half value becomes a 32-bit single, or a 32-bit single becomes a 64-bit double. No result ever needs rounding, so the converter has no rounding path. It does only four things. It rebiases normal numbers, and it renormalises subnormal sources into normal destination numbers. Zeros and infinities keep their sign. NaNs are made quiet, or they are replaced by a canonical NaN when default-NaN mode is on.

The block also reports an invalid-operation flag whenever the source is a signalling NaN. With `REGISTERED` set, one pipeline stage with a valid qualifier sits behind the combinational path. With `REGISTERED` cleared, outputs follow the inputs in the same cycle.

Top module: `fp_widen`

## Requirements
- R1: With `mode`=0 the source is `src_bits[15:0]` (sign 15, exponent 14:10, fraction 9:0). The result is a single in `dst_bits[31:0]` (sign 31, exponent 30:23, fraction 22:0), `dst_bits[63:32]` is zero and `src_bits[31:16]` has no effect. With `mode`=1 the source is `src_bits[31:0]` as a single and the result is a double (sign 63, exponent 62:52, fraction 51:0).
- R2: A normal source keeps its sign. Its exponent is rebiased: +112 for half to single, +896 for single to double. Its fraction is left-aligned in the wider field, with zeros below.
- R3: A subnormal source (exponent 0, nonzero fraction) becomes a normal result of the same value. The fraction is shifted left past its leading one, that one is dropped, and the exponent is (bias difference) minus the leading-zero count of the source fraction.
- R4: A zero or an infinity source gives the destination zero or infinity with the same sign.
- R5: With `dn_en`=0, a NaN source (all-ones exponent, nonzero fraction) keeps its sign and gets an all-ones exponent. Its fraction is copied to the top of the destination fraction, with zeros below, and the destination quiet bit (22 for single, 51 for double) is set.
- R6: With `dn_en`=1, every NaN source gives 0x7FC00000 (single) or 0x7FF8000000000000 (double), whatever its sign or payload.
- R7: `invalid` is 1 exactly when the source is a NaN whose top fraction bit is 0 (signalling), in either `dn_en` setting. A quiet NaN or any other value gives 0.
- R8: With `REGISTERED`=1, results and `out_valid` appear one clock after `in_valid` is sampled. Synchronous active-low reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Source value present |
| mode | input | 1 | 0: half to single, 1: single to double |
| dn_en | input | 1 | Replace NaN results by the canonical NaN |
| src_bits | input | 32 | Raw source encoding |
| out_valid | output | 1 | Result present |
| dst_bits | output | 64 | Raw result encoding |
| invalid | output | 1 | Source was a signalling NaN |

## Verification
The bench targets the renormalisation ends: the lowest subnormal fraction bit and the highest one, in both formats. An off-by-one in the leading-zero count or the exponent offset would show there as a result that is double or half the true value. It also drives signalling and quiet NaNs with payloads in both `dn_en` settings. A converter that tested the wrong fraction bit for signalling, lost the payload shift, or let `dn_en` gate the flag would give a wrong `invalid` or NaN pattern. The bench further checks that garbage in the unused upper source half does not reach a half conversion, and that `out_valid` tracks `in_valid` with a one-cycle delay.

// File: rtl/fpw_pkg.sv
// Shared definitions for the widening converter.
// Assumes IEEE-754 binary16/32/64 encodings.
package fpw_pkg;

    // Value classes decoded from exponent and fraction fields
    typedef enum logic [2:0] {
        FC_ZERO = 3'd0,
        FC_SUB  = 3'd1,
        FC_NORM = 3'd2,
        FC_INF  = 3'd3,
        FC_QNAN = 3'd4,
        FC_SNAN = 3'd5
    } fp_class_e;

    localparam int HALF_EW = 5;
    localparam int HALF_FW = 10;
    localparam int SGL_EW  = 8;
    localparam int SGL_FW  = 23;
    localparam int DBL_EW  = 11;
    localparam int DBL_FW  = 52;

endpackage

// File: rtl/fpw_classify.sv
// Classifies one floating-point operand from its exponent and fraction.
// Assumes FW >= 1; the fraction MSB tells a quiet NaN from a signalling one.
module fpw_classify #(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW-1:0]          exp_i,
    input  logic [FW-1:0]          frac_i,
    output fpw_pkg::fp_class_e     cls_o
);
    import fpw_pkg::*;

    logic exp_zero;
    logic exp_ones;
    logic frac_zero;

    assign exp_zero  = (exp_i == '0);
    assign exp_ones  = (exp_i == '1);
    assign frac_zero = (frac_i == '0);

    // Decode the class from the field extremes
    always_comb begin
        if (exp_zero)
            cls_o = frac_zero ? FC_ZERO : FC_SUB;
        else if (exp_ones)
            cls_o = frac_zero ? FC_INF : (frac_i[FW-1] ? FC_QNAN : FC_SNAN);
        else
            cls_o = FC_NORM;
    end
endmodule

// File: rtl/fpw_widen.sv
// Widens one classified operand from a (SEW,SFW) format to a (DEW,DFW) format.
// Assumes DEW > SEW and DFW > SFW so every source value is exact in the target.
module fpw_widen #(
    parameter int SEW = 5,
    parameter int SFW = 10,
    parameter int DEW = 8,
    parameter int DFW = 23
) (
    input  logic                   sign_i,
    input  logic [SEW-1:0]         exp_i,
    input  logic [SFW-1:0]         frac_i,
    input  fpw_pkg::fp_class_e     cls_i,
    input  logic                   dn_en_i,
    output logic [DEW+DFW:0]       res_o,
    output logic                   invalid_o
);
    import fpw_pkg::*;

    localparam int SHIFT    = DFW - SFW;
    localparam int BIAS_ADJ = (2 ** (DEW - 1) - 1) - (2 ** (SEW - 1) - 1);
    localparam int LZW      = $clog2(SFW + 1);

    logic [LZW-1:0] lz;
    logic [SFW-1:0] renorm_frac;
    logic [DEW-1:0] renorm_exp;
    logic [DEW-1:0] rebias_exp;
    logic [DFW-1:0] wide_frac;
    logic [DFW-1:0] nan_frac;

    // Leading-zero count of the source fraction, searched from the MSB
    always_comb begin
        logic found;
        lz    = '0;
        found = 1'b0;
        for (int i = SFW - 1; i >= 0; i--) begin
            if (!found && frac_i[i]) begin
                lz    = LZW'(SFW - 1 - i);
                found = 1'b1;
            end
        end
    end

    assign renorm_frac = frac_i << (lz + LZW'(1));
    assign renorm_exp  = DEW'(BIAS_ADJ) - DEW'(lz);
    assign rebias_exp  = DEW'(exp_i) + DEW'(BIAS_ADJ);
    assign wide_frac   = {frac_i, {SHIFT{1'b0}}};
    assign nan_frac    = wide_frac | {1'b1, {(DFW-1){1'b0}}};

    // Assemble the destination encoding per source class
    always_comb begin
        invalid_o = (cls_i == FC_SNAN);
        unique case (cls_i)
            FC_ZERO: res_o = {sign_i, {DEW{1'b0}}, {DFW{1'b0}}};
            FC_SUB:  res_o = {sign_i, renorm_exp, renorm_frac, {SHIFT{1'b0}}};
            FC_NORM: res_o = {sign_i, rebias_exp, wide_frac};
            FC_INF:  res_o = {sign_i, {DEW{1'b1}}, {DFW{1'b0}}};
            default: begin
                if (dn_en_i)
                    res_o = {1'b0, {DEW{1'b1}}, 1'b1, {(DFW-1){1'b0}}};
                else
                    res_o = {sign_i, {DEW{1'b1}}, nan_frac};
            end
        endcase
    end
endmodule

// File: rtl/fpw_stage.sv
// Optional output stage: one valid-qualified register or a straight wire.
// Assumes synchronous active-low reset; reset clears valid and data.
module fpw_stage #(
    parameter int W   = 65,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] dat_i,
    output logic         vld_o,
    output logic [W-1:0] dat_o
);
    generate
        if (REG) begin : g_reg
            // Capture the converted word each cycle, cleared by reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_o <= 1'b0;
                    dat_o <= '0;
                end else begin
                    vld_o <= vld_i;
                    dat_o <= dat_i;
                end
            end
        end else begin : g_wire
            assign vld_o = vld_i;
            assign dat_o = dat_i;
        end
    endgenerate
endmodule

// File: rtl/fp_widen.sv
// Top: half->single (mode 0) or single->double (mode 1) widening converter.
// Assumes raw IEEE-754 encodings; flush-to-zero and trapping are not modelled.
module fp_widen #(
    parameter bit REGISTERED = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        mode,
    input  logic        dn_en,
    input  logic [31:0] src_bits,
    output logic        out_valid,
    output logic [63:0] dst_bits,
    output logic        invalid
);
    import fpw_pkg::*;

    localparam int SW = 1 + SGL_EW + SGL_FW;
    localparam int DW = 1 + DBL_EW + DBL_FW;

    fp_class_e     h_cls, s_cls;
    logic [SW-1:0] h2s_res;
    logic [DW-1:0] s2d_res;
    logic          h2s_inv, s2d_inv;
    logic [DW-1:0] sel_res;
    logic          sel_inv;
    logic [DW:0]   stage_q;

    fpw_classify #(.EW(HALF_EW), .FW(HALF_FW)) u_cls_h (
        .exp_i (src_bits[14:10]),
        .frac_i(src_bits[9:0]),
        .cls_o (h_cls)
    );

    fpw_classify #(.EW(SGL_EW), .FW(SGL_FW)) u_cls_s (
        .exp_i (src_bits[30:23]),
        .frac_i(src_bits[22:0]),
        .cls_o (s_cls)
    );

    fpw_widen #(.SEW(HALF_EW), .SFW(HALF_FW), .DEW(SGL_EW), .DFW(SGL_FW)) u_h2s (
        .sign_i   (src_bits[15]),
        .exp_i    (src_bits[14:10]),
        .frac_i   (src_bits[9:0]),
        .cls_i    (h_cls),
        .dn_en_i  (dn_en),
        .res_o    (h2s_res),
        .invalid_o(h2s_inv)
    );

    fpw_widen #(.SEW(SGL_EW), .SFW(SGL_FW), .DEW(DBL_EW), .DFW(DBL_FW)) u_s2d (
        .sign_i   (src_bits[31]),
        .exp_i    (src_bits[30:23]),
        .frac_i   (src_bits[22:0]),
        .cls_i    (s_cls),
        .dn_en_i  (dn_en),
        .res_o    (s2d_res),
        .invalid_o(s2d_inv)
    );

    // Pick the conversion named by mode, zero-extending the single result
    always_comb begin
        if (mode) begin
            sel_res = s2d_res;
            sel_inv = s2d_inv;
        end else begin
            sel_res = {{(DW-SW){1'b0}}, h2s_res};
            sel_inv = h2s_inv;
        end
    end

    fpw_stage #(.W(DW + 1), .REG(REGISTERED)) u_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .vld_i(in_valid),
        .dat_i({sel_inv, sel_res}),
        .vld_o(out_valid),
        .dat_o(stage_q)
    );

    assign invalid  = stage_q[DW];
    assign dst_bits = stage_q[DW-1:0];
endmodule

// File: rtl/fpw_widen_chk.sv
// Port-level properties of fp_widen, bound into every instance.
// Assumes mode/src/dn_en are sampled with in_valid.
module fpw_widen_chk #(
    parameter bit REGISTERED = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        mode,
    input logic        dn_en,
    input logic [31:0] src_bits,
    input logic        out_valid,
    input logic [63:0] dst_bits,
    input logic        invalid
);
    logic h_nan, s_nan, h_snan, s_snan;
    assign h_nan  = (src_bits[14:10] == 5'h1f) && (src_bits[9:0] != 10'h0);
    assign s_nan  = (src_bits[30:23] == 8'hff) && (src_bits[22:0] != 23'h0);
    assign h_snan = h_nan && !src_bits[9];
    assign s_snan = s_nan && !src_bits[22];

    generate
        if (REGISTERED) begin : g_seq
            assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !mode) |=> (dst_bits[63:32] == 32'h0));
            assert_dn_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !mode && dn_en && h_nan) |=> (dst_bits == 64'h7FC00000));
            assert_dn_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && mode && dn_en && s_nan) |=> (dst_bits == 64'h7FF8000000000000));
            assert_snan_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (invalid == $past(mode ? s_snan : h_snan)));
            assert_nan_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && mode && s_nan) |=> dst_bits[51]);
        end else begin : g_comb
            assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> out_valid);
            assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !mode) |-> (dst_bits[63:32] == 32'h0));
            assert_dn_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !mode && dn_en && h_nan) |-> (dst_bits == 64'h7FC00000));
            assert_dn_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && mode && dn_en && s_nan) |-> (dst_bits == 64'h7FF8000000000000));
            assert_snan_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> (invalid == (mode ? s_snan : h_snan)));
        end
    endgenerate
endmodule

bind fp_widen fpw_widen_chk #(.REGISTERED(REGISTERED)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .mode     (mode),
    .dn_en    (dn_en),
    .src_bits (src_bits),
    .out_valid(out_valid),
    .dst_bits (dst_bits),
    .invalid  (invalid)
);

// File: tb/sim_fp_widen.sv
`timescale 1ns/1ps
// Directed bench for fp_widen in registered mode.
module sim_fp_widen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic        dn_en = 1'b0;
    logic [31:0] src_bits = 32'h0;
    logic        out_valid;
    logic [63:0] dst_bits;
    logic        invalid;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    fp_widen #(.REGISTERED(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .dn_en(dn_en), .src_bits(src_bits), .out_valid(out_valid),
        .dst_bits(dst_bits), .invalid(invalid)
    );

    // Record one comparison
    task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one conversion and check result, flag and valid one clock later
    task automatic conv(input string req, input logic m, input logic dn,
                        input logic [31:0] src, input logic [63:0] exp_res,
                        input logic exp_inv);
        @(negedge clk);
        in_valid = 1'b1; mode = m; dn_en = dn; src_bits = src;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {invalid, dst_bits}, {exp_inv, exp_res});
        check({req, " valid"}, {64'h0, out_valid}, 65'h1);
    endtask

    task automatic t_reset();
        check("R8 reset valid", {64'h0, out_valid}, 65'h0);
    endtask

    task automatic t_normal();
        conv("R2 h one",    1'b0, 1'b0, 32'h0000_3C00, 64'h3F80_0000, 1'b0);
        conv("R2 h -2.5",   1'b0, 1'b0, 32'h0000_C100, 64'hC020_0000, 1'b0);
        conv("R2 h max",    1'b0, 1'b0, 32'h0000_7BFF, 64'h477F_E000, 1'b0);
        conv("R2 h minnorm",1'b0, 1'b0, 32'h0000_0400, 64'h3880_0000, 1'b0);
        conv("R2 s one",    1'b1, 1'b0, 32'h3F80_0000, 64'h3FF0_0000_0000_0000, 1'b0);
        conv("R2 s -1.5",   1'b1, 1'b0, 32'hBFC0_0000, 64'hBFF8_0000_0000_0000, 1'b0);
    endtask

    task automatic t_upper_ignored();
        conv("R1 upper src ignored", 1'b0, 1'b0, 32'hABCD_3C00, 64'h3F80_0000, 1'b0);
    endtask

    task automatic t_subnormal();
        conv("R3 h lsb",  1'b0, 1'b0, 32'h0000_0001, 64'h3380_0000, 1'b0);
        conv("R3 h msb",  1'b0, 1'b0, 32'h0000_0200, 64'h3800_0000, 1'b0);
        conv("R3 h full", 1'b0, 1'b0, 32'h0000_83FF, 64'hB87F_C000, 1'b0);
        conv("R3 s lsb",  1'b1, 1'b0, 32'h0000_0001, 64'h36A0_0000_0000_0000, 1'b0);
        conv("R3 s msb",  1'b1, 1'b0, 32'h0040_0000, 64'h3800_0000_0000_0000, 1'b0);
    endtask

    task automatic t_zero_inf();
        conv("R4 h +0",   1'b0, 1'b0, 32'h0000_0000, 64'h0000_0000, 1'b0);
        conv("R4 h -0",   1'b0, 1'b0, 32'h0000_8000, 64'h8000_0000, 1'b0);
        conv("R4 h -inf", 1'b0, 1'b0, 32'h0000_FC00, 64'hFF80_0000, 1'b0);
        conv("R4 s -0",   1'b1, 1'b0, 32'h8000_0000, 64'h8000_0000_0000_0000, 1'b0);
        conv("R4 s +inf", 1'b1, 1'b0, 32'h7F80_0000, 64'h7FF0_0000_0000_0000, 1'b0);
    endtask

    task automatic t_nan_keep();
        conv("R5 h qnan payload R7", 1'b0, 1'b0, 32'h0000_7E01, 64'h7FC0_2000, 1'b0);
        conv("R5 h snan payload R7", 1'b0, 1'b0, 32'h0000_FC01, 64'hFFC0_2000, 1'b1);
        conv("R5 s snan payload R7", 1'b1, 1'b0, 32'h7F80_0001, 64'h7FF8_0000_2000_0000, 1'b1);
    endtask

    task automatic t_nan_default();
        conv("R6 h snan dn R7", 1'b0, 1'b1, 32'h0000_7C01, 64'h7FC0_0000, 1'b1);
        conv("R6 s qnan dn R7", 1'b1, 1'b1, 32'hFFC0_0000, 64'h7FF8_0000_0000_0000, 1'b0);
        conv("R6 s neg snan dn R7", 1'b1, 1'b1, 32'hFF80_1234, 64'h7FF8_0000_0000_0000, 1'b1);
    endtask

    task automatic t_idle();
        @(negedge clk);
        in_valid = 1'b0; src_bits = 32'h0000_3C00;
        @(negedge clk);
        check("R8 idle valid low", {64'h0, out_valid}, 65'h0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_normal();
        t_upper_ignored();
        t_subnormal();
        t_zero_inf();
        t_nan_keep();
        t_nan_default();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule